// File: doc/BRIEF.md
# Serial Port Bit-Clock Divider

This block makes the serial data bit clock for the transmitter and receiver of a buffered serial port. It takes a source tick from one of two places and divides it by a programmable ratio. The internal source ticks on every system clock cycle. The external source is a clock pin that is brought into the system domain through a flop chain, then edge-detected so that it gives one tick per rising edge. The divided clock comes out as a level. Two single-cycle strobes mark its rising and falling transitions, and the later frame-width and frame-period stages use those strobes.

An 8-bit divide value `D` sets the ratio to `D + 1`, so the ratio runs from 1 to 256. One counter counts source ticks within the period and restarts from zero at the end of each period. The high phase lasts `floor(D/2) + 1` ticks:

- An odd `D` gives a symmetric clock.
- An even nonzero `D` gives a high phase one tick longer than the low phase.
- `D = 0` passes the source straight through.

The divide value and the source choice are captured only when a period starts. Software can therefore change them at any time without producing a runt or stretched period.

Top module: `bitclk_divider`

## Requirements
- R1: With `src_int` = 1 the divider advances on every system clock cycle. With `src_int` = 0 it advances once per rising edge of `ext_clk`, after a two-flop synchroniser and an edge detector.
- R2: One bit-clock period (rise strobe to rise strobe) lasts `div_val + 1` source ticks, for every value from 0 to 255.
- R3: For an odd `div_val`, the high and low phases each last `(div_val + 1) / 2` source ticks.
- R4: For an even nonzero `div_val` = 2p, the high phase lasts p + 1 source ticks and the low phase lasts p source ticks.
- R5: For `div_val` = 0, `bclk_rise` and `bclk_fall` both pulse in the cycle after every source tick. `bclk` is high in exactly that cycle, so it is constantly high with the internal source.
- R6: `bclk_rise` is a one-cycle strobe in the cycle where `bclk` first reads 1. For a nonzero divide value, `bclk_fall` is a one-cycle strobe in the cycle where `bclk` first reads 0.
- R7: `div_val` and `src_int` are sampled only at the tick that starts a new period. A change made during a period leaves that period's high and low lengths unchanged.
- R8: While `rst` is high (synchronous), `bclk`, `bclk_rise` and `bclk_fall` are 0. The first source tick after reset starts a high phase, and `bclk_rise` and `bclk` read 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_int | input | 1 | Source choice: 1 = internal (every cycle), 0 = external pin |
| ext_clk | input | 1 | External source clock, asynchronous to `clk` |
| div_val | input | DIV_W | Divide value D; the ratio is D + 1 |
| bclk | output | 1 | Bit-clock level |
| bclk_rise | output | 1 | One-cycle strobe on a bit-clock rising transition |
| bclk_fall | output | 1 | One-cycle strobe on a bit-clock falling transition |

## Verification
The bench builds the block with its defaults: an 8-bit divide value and a two-stage synchroniser. This puts the whole ratio range within reach, including the 255 and 256 extremes. The external pin is driven at a quarter of the system rate, so every external phase length is a whole multiple of four system cycles. Mid-period writes can be measured against the period they land in, and swapping both the divide value and the source at once also tests the capture point of the source choice.

// File: rtl/bclk_div_pkg.sv
package bclk_div_pkg;

  // Source ticks spent high in one period for divide value d.
  function automatic int unsigned high_ticks(input int unsigned d);
    return (d / 2) + 1;
  endfunction

  // Source ticks spent low in one period for divide value d.
  function automatic int unsigned low_ticks(input int unsigned d);
    return d - (d / 2);
  endfunction

endpackage

// File: rtl/bclk_tick_src.sv
module bclk_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic use_int,
  input  logic ext_clk,
  output logic ext_tick,
  output logic tick
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      prev_q <= sync_q[MSB];
    end
  end

  assign ext_tick = sync_q[MSB] & ~prev_q;
  assign tick     = use_int | ext_tick;

endmodule

// File: rtl/bclk_counter.sv
module bclk_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_in,
  input  logic             sel_in,
  output logic             sel_cur,
  output logic [DIV_W-1:0] div_cur,
  output logic [DIV_W-1:0] cnt,
  output logic             reload,
  output logic             div_zero,
  output logic             bclk,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt_q, div_q, cnt_nxt, high_len;
  logic             sel_q, bclk_q, rise_q, fall_q;

  assign high_len = DIV_W'(bclk_div_pkg::high_ticks(int'(div_q)));
  assign cnt_nxt  = cnt_q + 1'b1;
  assign reload   = tick && (cnt_q == div_q);
  assign div_zero = (div_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      div_q  <= '0;
      sel_q  <= sel_in;
      bclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (reload) begin
        cnt_q  <= '0;
        div_q  <= div_in;
        sel_q  <= sel_in;
        bclk_q <= 1'b1;
        rise_q <= 1'b1;
        fall_q <= (div_in == '0);
      end else if (tick) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt == high_len) begin
          bclk_q <= 1'b0;
          fall_q <= 1'b1;
        end
      end else if (div_zero && bclk_q) begin
        bclk_q <= 1'b0;
      end
    end
  end

  assign sel_cur = sel_q;
  assign div_cur = div_q;
  assign cnt     = cnt_q;
  assign bclk    = bclk_q;
  assign rise    = rise_q;
  assign fall    = fall_q;

endmodule

// File: rtl/bitclk_divider.sv
module bitclk_divider #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_int,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div_val,
  output logic             bclk,
  output logic             bclk_rise,
  output logic             bclk_fall
);

  logic             sel_cur;
  logic             ext_tick;
  logic             src_tick;
  logic             reload;
  logic             div_zero;
  logic [DIV_W-1:0] div_cur;
  logic [DIV_W-1:0] cnt_cur;

  bclk_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst      (rst),
    .use_int  (sel_cur),
    .ext_clk  (ext_clk),
    .ext_tick (ext_tick),
    .tick     (src_tick)
  );

  bclk_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (src_tick),
    .div_in   (div_val),
    .sel_in   (src_int),
    .sel_cur  (sel_cur),
    .div_cur  (div_cur),
    .cnt      (cnt_cur),
    .reload   (reload),
    .div_zero (div_zero),
    .bclk     (bclk),
    .rise     (bclk_rise),
    .fall     (bclk_fall)
  );

endmodule

// File: rtl/bclk_div_checker.sv
module bclk_div_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_cur,
  input logic             ext_tick,
  input logic             tick,
  input logic             reload,
  input logic             div_zero,
  input logic [DIV_W-1:0] div_cur,
  input logic [DIV_W-1:0] cnt,
  input logic             bclk,
  input logic             bclk_rise,
  input logic             bclk_fall
);

  AST_RISE_HAS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |-> bclk); // R6

  AST_ROSE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk) |-> bclk_rise); // R6

  AST_FELL_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk) |-> (bclk_fall || $past(div_zero))); // R6

  AST_FALL_HAS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (bclk_fall && !bclk_rise) |-> !bclk); // R6

  AST_STROBE_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (rst)
    (bclk_rise || bclk_fall) |-> $past(tick)); // R1

  AST_EXT_TICK_ONLY_EXT: assert property (@(posedge clk) disable iff (rst)
    (!sel_cur && tick) |-> ext_tick); // R1

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= div_cur); // R2

  AST_DIV_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(div_cur)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!bclk && !bclk_rise && !bclk_fall)); // R8

endmodule

bind bitclk_divider bclk_div_checker #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_cur   (sel_cur),
  .ext_tick  (ext_tick),
  .tick      (src_tick),
  .reload    (reload),
  .div_zero  (div_zero),
  .div_cur   (div_cur),
  .cnt       (cnt_cur),
  .bclk      (bclk),
  .bclk_rise (bclk_rise),
  .bclk_fall (bclk_fall)
);

// File: tb/test_bitclk_divider.sv
module test_bitclk_divider;

  localparam int DIV_W = 8;
  localparam int EXT_T = 4;      // system cycles per external clock period
  localparam int LIM   = 3000;   // per-wait cycle limit
  localparam int WDOG  = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             src_int = 1'b1;
  logic             ext_clk;
  logic [DIV_W-1:0] div_val = 8'd3;
  logic             bclk, bclk_rise, bclk_fall;
  logic [1:0]       ext_phase = 2'd0;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) ext_phase <= ext_phase + 2'd1;
  assign ext_clk = ext_phase[1];

  bitclk_divider #(.DIV_W(DIV_W), .SYNC_STAGES(2)) i_bitclk_divider (
    .clk(clk), .rst(rst), .src_int(src_int), .ext_clk(ext_clk),
    .div_val(div_val), .bclk(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
  );

  function automatic int exp_high(input int d);
    if (d == 0)          return 1;
    else if (d % 2 == 1) return (d + 1) / 2;
    else                 return d / 2 + 1;
  endfunction

  function automatic int exp_low(input int d);
    return (d + 1) - exp_high(d);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bclk_rise && n < LIM);
    if (n >= LIM) chk(1'b0, "R2 rise timeout", n, LIM);
  endtask

  task automatic phase_lengths(output int hi, output int lo);
    hi = 0;
    do begin @(negedge clk); hi++; end while (!bclk_fall && hi < LIM);
    lo = 0;
    do begin @(negedge clk); lo++; end while (!bclk_rise && lo < LIM);
  endtask

  task automatic measure(input int d, input bit intl);
    int t, hi, lo;
    string tag;
    t = intl ? 1 : EXT_T;
    tag = (d % 2 == 1) ? "R3" : "R4";
    src_int = intl;
    div_val = DIV_W'(d);
    wait_rise();
    wait_rise();
    phase_lengths(hi, lo);
    chk(hi == exp_high(d) * t, tag, hi, exp_high(d) * t);
    chk(lo == exp_low(d) * t, tag, lo, exp_low(d) * t);
    chk(hi + lo == (d + 1) * t, "R2", hi + lo, (d + 1) * t);
  endtask

  initial begin
    int hi, lo;
    void'($urandom(32'd2718));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(bclk == 1'b0 && bclk_rise == 1'b0 && bclk_fall == 1'b0, "R8 reset outputs",
        {bclk, bclk_rise, bclk_fall}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bclk_rise == 1'b1 && bclk == 1'b1, "R8 first rise", {bclk_rise, bclk}, 3);

    // R1 R2 R3 R4 directed, internal source
    measure(1, 1'b1);
    measure(2, 1'b1);
    measure(3, 1'b1);
    measure(254, 1'b1);
    measure(255, 1'b1);

    // R5 divide zero, internal source: level and both strobes every cycle
    src_int = 1'b1;
    div_val = '0;
    wait_rise();
    wait_rise();
    for (int i = 0; i < 8; i++) begin
      chk(bclk && bclk_rise && bclk_fall, "R5 internal d0", {bclk, bclk_rise, bclk_fall}, 7);
      @(negedge clk);
    end

    // R1 external source, directed divide values
    measure(1, 1'b0);
    measure(2, 1'b0);
    measure(3, 1'b0);
    measure(254, 1'b0);
    measure(255, 1'b0);

    // R5 divide zero, external source
    src_int = 1'b0;
    div_val = '0;
    wait_rise();
    wait_rise();
    chk(bclk_fall && bclk, "R5 external d0 strobes", {bclk_fall, bclk}, 3);
    begin
      int per = 0, highs = 0;
      do begin
        @(negedge clk);
        per++;
        if (!bclk_rise && bclk) highs++;
      end while (!bclk_rise && per < LIM);
      chk(per == EXT_T, "R1 external tick spacing", per, EXT_T);
      chk(highs == 0, "R5 external d0 single high cycle", highs, 0);
    end

    // R7 mid-period change of divide value and source
    measure(5, 1'b1);
    div_val = 8'd2;
    src_int = 1'b0;
    phase_lengths(hi, lo);
    chk(hi == 3, "R7 high kept", hi, 3);
    chk(lo == 3, "R7 low kept", lo, 3);
    measure(2, 1'b0);
    // R7 mid-high change back to internal
    src_int = 1'b0;
    div_val = 8'd4;
    wait_rise();
    wait_rise();
    repeat (2) @(negedge clk);
    div_val = 8'd9;
    src_int = 1'b1;
    lo = 0;
    do begin @(negedge clk); lo++; end while (!bclk_fall && lo < LIM);
    begin
      int lo2 = 0;
      do begin @(negedge clk); lo2++; end while (!bclk_rise && lo2 < LIM);
      chk(lo2 == 2 * EXT_T, "R7 low kept after source swap", lo2, 2 * EXT_T);
    end

    // Constrained random, both sources
    for (int k = 0; k < 10; k++) begin
      measure(int'($urandom % 255) + 1, 1'b1);
    end
    for (int k = 0; k < 4; k++) begin
      measure(int'($urandom % 16) + 1, 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG && !done) begin
      n_vec = n_vec + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule